// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an 8-bit general-purpose I/O port behind a simple memory-mapped register interface. It has one data register and one direction register. The data register answers at 256 word-aligned byte offsets from 0x000 to 0x3FC. Address bits [9:2] of an access act as a per-bit mask, and the mask applies to writes and reads alike. Separate software drivers can therefore each own a few pins and update them with a single store, with no read-modify-write and no race between drivers.

The direction register sits at 0x400. Its output-enable bits drive the pads' output enables. A pin configured as an output drives the stored data bit. A pin configured as an input has its level passed through a synchronizer before software reads it. Read data is registered and appears on the bus one clock after the read strobe.

Top module: `gpio_amask_port`

## Requirements
- R1: After reset, the stored data, the direction register, `pin_out`, `pin_oe` and `bus_rdata` are all 0, so every pin starts as an input.
- R2: A write to the data window (byte offsets 0x000–0x3FC) updates stored data bit n only when byte-address bit n+2 is 1. Every other bit keeps its value, and an all-zero mask changes nothing.
- R3: `pin_oe` equals the direction register, where 1 means output. `pin_out` bit n carries stored data bit n only while `pin_oe` bit n is 1, and is 0 otherwise.
- R4: A data-window read returns 0 in every bit whose mask bit (byte-address bit n+2) is 0. `bus_rdata` bits 31:8 always read 0.
- R5: In a data-window read with the mask bit set, an output pin returns its stored data bit and an input pin returns its synchronized pin level.
- R6: A write to byte offset 0x400 loads all 8 direction bits from `bus_wdata`, with no address mask. A read of 0x400 returns them.
- R7: `bus_rdata` holds the result of a read strobed on the previous rising edge. It is 0 in any cycle that follows an edge with no read strobe. Back-to-back reads return one result per cycle.
- R8: A masked write to an input pin stores the bit without driving it. The stored value appears on `pin_out` once the pin is switched to output.
- R9: A change on `pin_in` is invisible to a read strobed in the cycle of the change or in the next cycle. It is visible to a read strobed two cycles after the change.
- R10: Byte offsets outside the data window and outside 0x400 read as 0, and writes to them change neither data nor direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Word address, byte-address bits [11:2] |
| bus_wr | input | 1 | Write strobe, acts on the rising edge where it is high |
| bus_rd | input | 1 | Read strobe, result on `bus_rdata` one cycle later |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Asynchronous pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
Writes take effect on the edge that samples `bus_wr`, so the bench checks `pin_out` and `pin_oe` at the falling edge right after that edge. Read results are due one edge after the read strobe. The driver pushes each expected word into a queue when it raises `bus_rd`. A monitor pops that word 2 ns after the following rising edge and compares it. In edges without a read strobe, the monitor instead checks that `bus_rdata` is 0. Input levels need two more edges to pass the synchronizer, so the bench lets pins settle for at least three cycles before reading them. The R9 case reads in the change cycle, one cycle later and two cycles later, and expects old, old, then new.

// File: rtl/gpio_amask_pkg.sv
package gpio_amask_pkg;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_DATA = 2'd1,
      ACC_DIR  = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/gpio_amask_decode.sv
module gpio_amask_decode
   import gpio_amask_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 12,
   parameter int DIR_OFFSET = 'h400
) (
   input  logic [ADDR_W-1:2] addr,
   output acc_kind_e         kind,
   output logic [DATA_W-1:0] mask
);
   localparam int WIN_LSB = DATA_W + 2;
   localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

   logic in_window;
   logic is_dir;

   assign in_window = (addr[ADDR_W-1:WIN_LSB] == '0);
   assign is_dir    = (addr == DIR_ADDR[ADDR_W-1:2]);
   assign mask      = addr[WIN_LSB-1:2];

   always_comb begin
      if (in_window)   kind = ACC_DATA;
      else if (is_dir) kind = ACC_DIR;
      else             kind = ACC_NONE;
   end
endmodule

// File: rtl/gpio_amask_sync.sv
module gpio_amask_sync #(
   parameter int DATA_W = 8,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] async_in,
   output logic [DATA_W-1:0] sync_out
);
   logic [DATA_W-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_amask_store.sv
module gpio_amask_store
   import gpio_amask_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  acc_kind_e         kind,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] dir_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (wr_en && kind == ACC_DATA) begin
         data_q <= (data_q & ~mask) | (wdata & mask);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (wr_en && kind == ACC_DIR) begin
         dir_q <= wdata;
      end
   end
endmodule

// File: rtl/gpio_amask_rdpath.sv
module gpio_amask_rdpath
   import gpio_amask_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BUS_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  acc_kind_e         kind,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] data_q,
   input  logic [DATA_W-1:0] dir_q,
   input  logic [DATA_W-1:0] pin_sync,
   output logic [BUS_W-1:0]  rdata
);
   logic [DATA_W-1:0] live;
   logic [DATA_W-1:0] word;

   assign live = (dir_q & data_q) | (~dir_q & pin_sync);

   always_comb begin
      case (kind)
         ACC_DATA: word = live & mask;
         ACC_DIR:  word = dir_q;
         default:  word = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= BUS_W'(word);
      else            rdata <= '0;
   end
endmodule

// File: rtl/gpio_amask_port.sv
module gpio_amask_port
   import gpio_amask_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 12,
   parameter int BUS_W       = 32,
   parameter int DIR_OFFSET  = 'h400,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:2] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] pin_out,
   output logic [DATA_W-1:0] pin_oe
);
   localparam int WIN_BYTES = 1 << (DATA_W + 2);

   generate
      if (DATA_W < 1 || DATA_W > 16) begin : g_bad_width
         $error("gpio_amask_port: DATA_W out of range");
      end
      if (BUS_W < DATA_W) begin : g_bad_bus
         $error("gpio_amask_port: BUS_W narrower than DATA_W");
      end
      if (ADDR_W < DATA_W + 3) begin : g_bad_addr
         $error("gpio_amask_port: ADDR_W leaves no room beyond the data window");
      end
      if (DIR_OFFSET < WIN_BYTES || DIR_OFFSET >= (1 << ADDR_W) || (DIR_OFFSET % 4) != 0) begin : g_bad_dir
         $error("gpio_amask_port: DIR_OFFSET must be word aligned and outside the data window");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_amask_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   acc_kind_e         acc_kind;
   logic [DATA_W-1:0] acc_mask;
   logic [DATA_W-1:0] store_data;
   logic [DATA_W-1:0] store_dir;
   logic [DATA_W-1:0] pin_sync;

   gpio_amask_decode #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .DIR_OFFSET (DIR_OFFSET)
   ) decode_i (
      .addr (bus_addr),
      .kind (acc_kind),
      .mask (acc_mask)
   );

   gpio_amask_store #(
      .DATA_W (DATA_W)
   ) store_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr),
      .kind   (acc_kind),
      .mask   (acc_mask),
      .wdata  (bus_wdata),
      .data_q (store_data),
      .dir_q  (store_dir)
   );

   gpio_amask_sync #(
      .DATA_W (DATA_W),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   gpio_amask_rdpath #(
      .DATA_W (DATA_W),
      .BUS_W  (BUS_W)
   ) rdpath_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (bus_rd),
      .kind     (acc_kind),
      .mask     (acc_mask),
      .data_q   (store_data),
      .dir_q    (store_dir),
      .pin_sync (pin_sync),
      .rdata    (bus_rdata)
   );

   assign pin_oe  = store_dir;
   assign pin_out = store_data & store_dir;
endmodule

// File: rtl/gpio_amask_chk.sv
module gpio_amask_chk #(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 12,
   parameter int BUS_W      = 32,
   parameter int DIR_OFFSET = 'h400
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:2] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic [DATA_W-1:0] pin_out,
   input logic [DATA_W-1:0] pin_oe,
   input logic [DATA_W-1:0] data_q
);
   localparam int WIN_LSB = DATA_W + 2;
   localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

   logic              c_win;
   logic              c_dir;
   logic [DATA_W-1:0] c_mask;

   assign c_win  = (bus_addr[ADDR_W-1:WIN_LSB] == '0);
   assign c_dir  = (bus_addr == DIR_ADDR[ADDR_W-1:2]);
   assign c_mask = bus_addr[WIN_LSB-1:2];

   assert_masked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && c_win) |=> ((data_q & ~$past(c_mask)) == ($past(data_q) & ~$past(c_mask))));

   assert_masked_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && c_win) |=> ((data_q & $past(c_mask)) == ($past(bus_wdata) & $past(c_mask))));

   assert_no_write_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && c_win) |=> $stable(data_q));

   assert_drive_only_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out & ~pin_oe) == '0));

   assert_dir_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && c_dir) |=> (pin_oe == $past(bus_wdata)));

   assert_read_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && c_win) |=> ((bus_rdata[DATA_W-1:0] & ~$past(c_mask)) == '0));

   assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[BUS_W-1:DATA_W] == '0));

   assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));
endmodule

bind gpio_amask_port gpio_amask_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .BUS_W      (BUS_W),
   .DIR_OFFSET (DIR_OFFSET)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .data_q    (store_data)
);

// File: tb/gpio_amask_port_tb_top.sv
module gpio_amask_port_tb_top;
   localparam int DW = 8;
   localparam int AW = 12;
   localparam int BW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:2] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [BW-1:0] bus_rdata;
   logic [DW-1:0] pin_in = '0;
   logic [DW-1:0] pin_out;
   logic [DW-1:0] pin_oe;

   int checks = 0;
   int failures = 0;
   logic [BW-1:0] exp_q [$];
   string         tag_q [$];

   always #4 clk = ~clk;

   gpio_amask_port dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      bus_addr  = a[AW-1:2];
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, logic [BW-1:0] exp, string req);
      bus_addr = a[AW-1:2];
      bus_rd   = 1'b1;
      exp_q.push_back(exp);
      tag_q.push_back(req);
      @(negedge clk);
      bus_rd   = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Monitor: a read strobed at an edge is due 2 ns after that edge (R7).
   always @(posedge clk) begin
      logic seen;
      seen = bus_rd && rst_n;
      #2;
      if (seen) begin
         if (exp_q.size() == 0) begin
            check("R7 unexpected read", 32'h1, 32'h0);
         end else begin
            logic [BW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, bus_rdata, e);
         end
      end else if (rst_n) begin
         check("R7 idle zero", bus_rdata, '0);
      end
   end

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      idle(3);
      check("R1 pin_out reset", BW'(pin_out), '0);
      check("R1 pin_oe reset", BW'(pin_oe), '0);
      check("R1 rdata reset", bus_rdata, '0);
      rst_n = 1'b1;
      idle(1);
      rd(12'h3FC, 32'h00, "R1 data reads zero");

      wr(12'h400, 8'hF0);
      check("R6 pin_oe after dir write", BW'(pin_oe), 32'hF0);
      rd(12'h400, 32'hF0, "R6 dir readback");

      wr(12'h3FC, 8'hA5);
      check("R3 pin_out gated by dir", BW'(pin_out), 32'hA0);

      wr(12'h0C0, 8'hFF);
      check("R2 masked write bits 5:4", BW'(pin_out), 32'hB0);
      wr(12'h000, 8'h00);
      check("R2 zero mask no change", BW'(pin_out), 32'hB0);

      pin_in = 8'h3C;
      idle(3);
      rd(12'h3FC, 32'hBC, "R5 mixed out/in read");
      rd(12'h204, 32'h80, "R4 masked read");
      rd(12'h03C, 32'h0C, "R4 low mask read");

      // R9: change and read in the same cycle, then the next two cycles
      pin_in = 8'hC3;
      rd(12'h03C, 32'h0C, "R9 read in change cycle");
      rd(12'h03C, 32'h0C, "R9 read one cycle later");
      rd(12'h03C, 32'h03, "R9 read two cycles later");

      wr(12'h03C, 8'h0A);
      check("R8 input write not driven", BW'(pin_out), 32'hB0);
      rd(12'h03C, 32'h03, "R8 input read shows pins");
      wr(12'h400, 8'hFF);
      check("R8 stored bits driven after dir", BW'(pin_out), 32'hBA);
      rd(12'h3FC, 32'hBA, "R5 all outputs read stored");

      wr(12'h800, 8'h00);
      wr(12'h404, 8'h00);
      check("R10 pin_out unchanged", BW'(pin_out), 32'hBA);
      check("R10 pin_oe unchanged", BW'(pin_oe), 32'hFF);
      rd(12'h800, 32'h0, "R10 unmapped read");
      rd(12'h404, 32'h0, "R10 unmapped read near dir");
      rd(12'h400, 32'hFF, "R6 dir readback full");
      idle(1);
      rd(12'h3FC, 32'hBA, "R7 read after idle");

      rst_n = 1'b0;
      idle(2);
      check("R1 pin_out mid-run reset", BW'(pin_out), '0);
      check("R1 pin_oe mid-run reset", BW'(pin_oe), '0);
      check("R1 rdata mid-run reset", bus_rdata, '0);
      rst_n = 1'b1;
      idle(3);
      rd(12'h3FC, 32'hC3, "R1 inputs after reset");
      idle(2);
      check("R7 queue drained", BW'(exp_q.size()), '0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule